// File: doc/BRIEF.md
# DMA Page Translator

This block turns a bus address issued by a DMA-capable device into a physical address. It holds a single-level table of 64-bit translation entries in on-chip storage. The page size is a power of two chosen at run time. A request's bus address is shifted right by the page shift to form a table index, and the entry at that index supplies both the physical page and the access rights for that page.

Requests arrive on a valid/ready stream carrying a bus address and a read/write flag. Each accepted request produces one response exactly one cycle later on a second valid/ready stream. The response carries:

- the final physical address,
- the translated page address,
- the page base of the bus address,
- the in-page offset mask,
- the two-bit permission of the entry,
- an allow flag and a fault flag.

Back-pressure is simple. The request side is ready whenever the single output slot is empty or is being drained in the same cycle. A stalled response holds all its fields unchanged until the consumer takes it.

A separate write port loads table entries one at a time. Reset makes every entry read as zero, so every page faults until software programs it. The page shift and the number of live entries are plain configuration inputs.

Top module: `dma_page_xlat`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, and every table entry reads as zero. A lookup of an entry never written since reset therefore returns permission 0, with `rsp_allow`=0 and `rsp_fault`=1.
- R2: The table index is `req_addr` shifted right by the effective page shift. The effective shift is `cfg_page_shift`, raised to 12 when below 12 and lowered to 24 when above 24.
- R3: When the index is not less than the effective entry count, the lookup is out of range. The effective count is `cfg_entry_count` capped at the table depth (256 by default). An out-of-range response has:
  - permission 0 and `rsp_fault`=1,
  - a zero page address and a zero page base,
  - an all-ones offset mask,
  - `rsp_phys` equal to the zero-extended bus address.
- R4: `rsp_perm` is entry bits [1:0], encoded as follows: 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R5: `rsp_allow` is 1 exactly when the permission covers the request. A write (`req_write`=1) needs permission bit 1, and a read needs permission bit 0. `rsp_fault` is the inverse of `rsp_allow`.
- R6: The page mask has ones at bit positions at or above the effective shift. Within range:
  - `rsp_page_addr` is the entry ANDed with the page mask,
  - `rsp_page_base` is the bus address ANDed with the page mask,
  - `rsp_offset_mask` is the complement of the page mask.
- R7: `rsp_phys` equals `rsp_page_addr` ORed with the zero-extended bus address ANDed with `rsp_offset_mask`.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1.
  - `req_ready` is 1 when `rsp_valid` is 0 or `rsp_ready` is 1.
  - The response for an accepted request is valid in the next cycle.
  - While `rsp_valid`=1 and `rsp_ready`=0, all response fields stay stable.
- R9: A table write is seen by lookups accepted in later cycles. A lookup accepted in the same cycle as a write to its own entry returns the entry's previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_page_shift | input | 5 | Requested page shift, clamped to 12..24 |
| cfg_entry_count | input | 9 | Number of live table entries |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 8 | Entry index to write |
| tbl_wr_data | input | 64 | Entry value to write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | 32 | Bus address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_phys | output | 64 | Final physical address |
| rsp_page_addr | output | 64 | Translated page address |
| rsp_offset_mask | output | 64 | In-page offset mask |
| rsp_page_base | output | 32 | Page base of the bus address |
| rsp_perm | output | 2 | Entry permission |
| rsp_allow | output | 1 | Access granted |
| rsp_fault | output | 1 | Access refused |

## Verification
Several properties are checked by assertions on every cycle:

- the effective shift stays inside 12..24,
- an accepted request produces a response on the next cycle,
- a stalled response does not move,
- an allowed access never carries permission 0,
- an all-ones offset mask always comes with a zero page and permission 0,
- the page base never overlaps the offset mask.

Other behaviour only the bench scenarios can show. This covers the actual translated values for several shifts and entries, and the clamping of out-of-bound shifts and counts. It also covers the read/write decision for each permission code, the stale read when a lookup and a write to the same entry coincide, and the zeroed content of entries never written.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  localparam int unsigned SHIFT_MIN = 12;
  localparam int unsigned SHIFT_MAX = 24;

endpackage

// File: rtl/xlat_geom.sv
module xlat_geom #(
  parameter int unsigned ENT_W   = 64,
  parameter int unsigned SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] cfg_shift,
  output logic [SHIFT_W-1:0] eff_shift,
  output logic [ENT_W-1:0]   page_mask
);
  import dma_xlat_pkg::*;

  localparam logic [SHIFT_W-1:0] LO = SHIFT_W'(SHIFT_MIN);
  localparam logic [SHIFT_W-1:0] HI = SHIFT_W'(SHIFT_MAX);

  always_comb begin
    if (cfg_shift < LO)      eff_shift = LO;
    else if (cfg_shift > HI) eff_shift = HI;
    else                     eff_shift = cfg_shift;
  end

  // one bit of the mask per position: set at or above the shift
  for (genvar g = 0; g < ENT_W; g++) begin : g_mask
    assign page_mask[g] = (32'(eff_shift) <= g);
  end

  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_shift >= LO) && (eff_shift <= HI)); // R2

endmodule

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int unsigned ENT_W = 64,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] store [DEPTH];
  logic [DEPTH-1:0] live;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     live <= '0;
    else if (wr_en) live[wr_idx] <= 1'b1;
  end

  assign rd_data = live[rd_idx] ? store[rd_idx] : '0;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> live[$past(wr_idx)]); // R9

endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check (
  input  logic [1:0] perm,
  input  logic       is_write,
  input  logic       in_range,
  output logic       allow,
  output logic       fault
);
  import dma_xlat_pkg::*;

  perm_e p;
  logic  covers;

  assign p = perm_e'(perm);

  always_comb begin
    unique case (p)
      PERM_NONE: covers = 1'b0;
      PERM_RD:   covers = !is_write;
      PERM_WR:   covers = is_write;
      PERM_RW:   covers = 1'b1;
      default:   covers = 1'b0;
    endcase
  end

  assign allow = in_range && covers;
  assign fault = !allow;

endmodule

// File: rtl/dma_page_xlat.sv
module dma_page_xlat #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENT_W   = 64,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] cfg_page_shift,
  input  logic [IDX_W:0]     cfg_entry_count,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_idx,
  input  logic [ENT_W-1:0]   tbl_wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ENT_W-1:0]   rsp_phys,
  output logic [ENT_W-1:0]   rsp_page_addr,
  output logic [ENT_W-1:0]   rsp_offset_mask,
  output logic [ADDR_W-1:0]  rsp_page_base,
  output logic [1:0]         rsp_perm,
  output logic               rsp_allow,
  output logic               rsp_fault
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0] DEPTH_CNT = (IDX_W+1)'(DEPTH);

  logic [SHIFT_W-1:0] eff_shift;
  logic [ENT_W-1:0]   page_mask;
  logic [ADDR_W-1:0]  idx_full;
  logic [IDX_W:0]     eff_count;
  logic               in_range;
  logic [ENT_W-1:0]   entry;
  logic               allow_n, fault_n;
  logic               accept;

  xlat_geom #(.ENT_W(ENT_W), .SHIFT_W(SHIFT_W)) u_geom (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_page_shift),
    .eff_shift(eff_shift), .page_mask(page_mask)
  );

  assign idx_full  = req_addr >> eff_shift;
  assign eff_count = (cfg_entry_count > DEPTH_CNT) ? DEPTH_CNT : cfg_entry_count;
  assign in_range  = idx_full < ADDR_W'(eff_count);

  xlat_table #(.ENT_W(ENT_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_data(tbl_wr_data),
    .rd_idx(idx_full[IDX_W-1:0]), .rd_data(entry)
  );

  logic [1:0] perm_n;
  assign perm_n = in_range ? entry[1:0] : 2'b00;

  xlat_perm_check u_perm (
    .perm(perm_n), .is_write(req_write), .in_range(in_range),
    .allow(allow_n), .fault(fault_n)
  );

  // next-state response fields
  logic [ENT_W-1:0]  page_n, mask_n, phys_n;
  logic [ADDR_W-1:0] base_n;

  always_comb begin
    if (in_range) begin
      page_n = entry & page_mask;
      mask_n = ~page_mask;
      base_n = req_addr & page_mask[ADDR_W-1:0];
    end else begin
      page_n = '0;
      mask_n = '1;
      base_n = '0;
    end
    phys_n = page_n | (ENT_W'(req_addr) & mask_n);
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_valid <= 1'b0;
    else if (accept)    rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_phys        <= '0;
      rsp_page_addr   <= '0;
      rsp_offset_mask <= '0;
      rsp_page_base   <= '0;
      rsp_perm        <= '0;
      rsp_allow       <= 1'b0;
      rsp_fault       <= 1'b0;
    end else if (accept) begin
      rsp_phys        <= phys_n;
      rsp_page_addr   <= page_n;
      rsp_offset_mask <= mask_n;
      rsp_page_base   <= base_n;
      rsp_perm        <= perm_n;
      rsp_allow       <= allow_n;
      rsp_fault       <= fault_n;
    end
  end

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_phys) && $stable(rsp_perm) && $stable(rsp_allow)); // R8
  AST_ALLOW_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_allow |-> rsp_perm != 2'b00); // R5
  AST_OOR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_offset_mask == '1) |-> (rsp_page_addr == '0) && (rsp_perm == 2'b00) && rsp_fault); // R3
  AST_BASE_MASK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_page_base & rsp_offset_mask[ADDR_W-1:0]) == '0); // R6

endmodule

// File: tb/dma_page_xlat_bench.sv
module dma_page_xlat_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_page_shift = 5'd12;
  logic [8:0]  cfg_entry_count = 9'd256;
  logic        tbl_wr_en = 1'b0;
  logic [7:0]  tbl_wr_idx = '0;
  logic [63:0] tbl_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_phys, rsp_page_addr, rsp_offset_mask;
  logic [31:0] rsp_page_base;
  logic [1:0]  rsp_perm;
  logic        rsp_allow, rsp_fault;

  always #4 clk = ~clk;

  dma_page_xlat u_dma_page_xlat (.*);

  typedef struct {
    logic [63:0] phys, page, mask;
    logic [31:0] base;
    logic [1:0]  perm;
    logic        allow;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [63:0] model_tbl [256];
  int          n_cmp = 0, n_bad = 0;
  bit          bp_on = 0;
  bit          done = 0;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [31:0] a, input logic w);
    exp_t e;
    int   s;
    int   cnt;
    logic [63:0] pm;
    logic [31:0] idx;
    s   = (cfg_page_shift < 12) ? 12 : (cfg_page_shift > 24) ? 24 : int'(cfg_page_shift);
    cnt = (cfg_entry_count > 256) ? 256 : int'(cfg_entry_count);
    idx = a >> s;
    if (idx >= 32'(cnt)) begin
      e.page = '0; e.mask = '1; e.base = '0; e.perm = 2'b00; e.allow = 1'b0;
    end else begin
      pm      = ~((64'd1 << s) - 64'd1);
      e.page  = model_tbl[idx[7:0]] & pm;
      e.mask  = ~pm;
      e.base  = a & pm[31:0];
      e.perm  = model_tbl[idx[7:0]][1:0];
      e.allow = w ? e.perm[1] : e.perm[0];
    end
    e.phys = e.page | ({32'd0, a} & e.mask);
    return e;
  endfunction

  task automatic tbl_write(input logic [7:0] i, input logic [63:0] d);
    tbl_wr_en = 1'b1; tbl_wr_idx = i; tbl_wr_data = d;
    @(posedge clk); #1;
    tbl_wr_en = 1'b0;
    model_tbl[i] = d;
  endtask

  task automatic lookup(input logic [31:0] a, input logic w, input string tag);
    exp_t e;
    e = predict(a, w);
    req_addr = a; req_write = w; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // R9: lookup and write to the same entry in one cycle
  task automatic lookup_with_write(input logic [31:0] a, input logic [7:0] i, input logic [63:0] d);
    exp_t e;
    e = predict(a, 1'b0);
    req_addr = a; req_write = 1'b0; req_valid = 1'b1;
    tbl_wr_en = 1'b1; tbl_wr_idx = i; tbl_wr_data = d;
    @(negedge clk);
    check(req_ready, "R9 ready for combined cycle", 64'(req_ready), 64'd1);
    exp_q.push_back(e); tag_q.push_back("R9 same-cycle old content");
    @(posedge clk); #1;
    req_valid = 1'b0; tbl_wr_en = 1'b0;
    model_tbl[i] = d;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  // response-side ready pattern
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      rsp_ready = bp_on ? ((k % 3) != 0) : 1'b1;
    end
  end

  // scoreboard monitor
  logic [63:0] hold_phys;
  logic [1:0]  hold_perm;
  bit          stall_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        check(rsp_valid && rsp_phys == hold_phys && rsp_perm == hold_perm,
              "R8 stalled response stable", rsp_phys, hold_phys);
      stall_prev = rsp_valid && !rsp_ready;
      hold_phys  = rsp_phys;
      hold_perm  = rsp_perm;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected response", rsp_phys, 64'd0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_cmp++;
          if (rsp_phys !== e.phys || rsp_page_addr !== e.page || rsp_offset_mask !== e.mask ||
              rsp_page_base !== e.base || rsp_perm !== e.perm || rsp_allow !== e.allow ||
              rsp_fault !== !e.allow) begin
            n_bad++;
            $display("FAIL %s actual phys=%h page=%h mask=%h base=%h perm=%0d allow=%0b fault=%0b expected phys=%h page=%h mask=%h base=%h perm=%0d allow=%0b",
                     t, rsp_phys, rsp_page_addr, rsp_offset_mask, rsp_page_base, rsp_perm, rsp_allow, rsp_fault,
                     e.phys, e.page, e.mask, e.base, e.perm, e.allow);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) model_tbl[i] = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(req_ready, "R1 req_ready after reset", 64'(req_ready), 64'd1);
    @(posedge clk); #1;

    lookup(32'h0000_0040, 1'b0, "R1 entry 0 zero after reset");
    lookup(32'h000C_8010, 1'b1, "R1 unwritten entry 200 faults");

    tbl_write(8'd0, 64'h0000_00AB_CDEF_1003);
    tbl_write(8'd1, 64'h0000_0000_5555_5001);
    tbl_write(8'd2, 64'h0000_0001_0000_0002);
    tbl_write(8'd3, 64'hFFFF_FFFF_FFFF_F000);
    tbl_write(8'd5, 64'h0000_0000_1234_5673);

    lookup(32'h0000_0123, 1'b0, "R4 R5 R6 R7 rw entry read");
    lookup(32'h0000_0123, 1'b1, "R5 rw entry write");
    lookup(32'h0000_1ABC, 1'b0, "R5 read-only entry read");
    lookup(32'h0000_1ABC, 1'b1, "R5 read-only entry write refused");
    lookup(32'h0000_2FFF, 1'b0, "R5 write-only entry read refused");
    lookup(32'h0000_2FFF, 1'b1, "R5 write-only entry write");
    lookup(32'h0000_3004, 1'b0, "R4 fault entry read");
    drain();

    cfg_page_shift = 5'd16;
    lookup(32'h0005_BEEF, 1'b1, "R2 R6 shift 16 entry 5");
    lookup(32'h0000_8000, 1'b0, "R2 shift 16 entry 0");
    drain();
    cfg_page_shift = 5'd3;
    lookup(32'h0000_1ABC, 1'b0, "R2 shift 3 clamps to 12");
    drain();
    cfg_page_shift = 5'd31;
    lookup(32'h0100_0010, 1'b0, "R2 shift 31 clamps to 24");
    lookup(32'h02FF_FFFF, 1'b1, "R2 shift 24 entry 2");
    drain();

    cfg_page_shift = 5'd12;
    cfg_entry_count = 9'd4;
    lookup(32'h0000_4000, 1'b0, "R3 index equals count");
    lookup(32'h0000_3FFF, 1'b0, "R3 last in-range index");
    lookup(32'hFFFF_F123, 1'b1, "R3 far out of range");
    drain();
    cfg_entry_count = 9'd300;
    lookup(32'h0010_0000, 1'b0, "R3 count capped at depth");
    lookup(32'h000F_F123, 1'b0, "R3 index 255 in range");
    drain();
    cfg_entry_count = 9'd0;
    lookup(32'h0000_0000, 1'b0, "R3 zero count");
    drain();
    cfg_entry_count = 9'd256;

    bp_on = 1;
    for (int k = 0; k < 16; k++)
      lookup({18'd0, 2'(k), 12'(k * 37)}, k[0], "R8 back-pressure stream");
    drain();
    bp_on = 0;
    drain();

    lookup_with_write(32'h0000_0010, 8'd0, 64'h0000_0000_7777_7001);
    lookup(32'h0000_0010, 1'b1, "R9 new content seen after write");
    lookup(32'h0000_0010, 1'b0, "R9 new content read");
    drain();

    summary();
  end

endmodule